// File: doc/BRIEF.md
# Ripple Probability Counter Pair

This block estimates how often a regulator output sits below a reference level. A comparator, asynchronous to the converter switching clock, delivers a one-bit verdict that is resynchronised and sampled on every clock. Two counters of equal width run side by side. The sample counter advances on every clock of a measurement. The hit counter advances only when the comparator says the output is below the reference.

A measurement begins with a start pulse. It ends by itself when the sample counter reaches its all-ones value, 2^W-1. At that point a done flag rises and both counts are frozen for readout. The fraction hit/(2^W-1) is the probability of the output being below that reference. Software steps the reference and repeats the measurement, issuing a synchronous clear before each new step. The sweep and the ripple computation stay outside the block.

Top module: `ripple_prob_counter`

## Requirements
- R1: While rst_ni is low, done_o is 0 and both counts read 0.
- R2: clear_i sampled high at a clock edge returns the block to idle, with both counts 0 and done_o 0, whatever state it was in.
- R3: In idle, neither counter moves. start_i sampled high in idle begins a measurement. The first counted sample is taken at the next clock edge.
- R4: During a measurement, ref_count_o increases by exactly one at every clock edge.
- R5: cmp_below_i = 1 means the output is below the reference. It passes through a two-flop synchronizer. The hit count increases at edge k exactly when cmp_below_i was 1 at edge k-2.
- R6: done_o rises at the edge where ref_count_o becomes 2^W-1, and not earlier.
- R7: Once done_o is set, both counts and done_o hold until clear_i or reset.
- R8: start_i has no effect while a measurement is running or after done_o is set.
- R9: When clear_i and start_i are both high, clear_i wins and the block stays idle.
- R10: hit_count_o never exceeds ref_count_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clear_i | input | 1 | Synchronous clear to idle |
| start_i | input | 1 | Begin a measurement from idle |
| cmp_below_i | input | 1 | Asynchronous comparator result, 1 = output below reference |
| done_o | output | 1 | Measurement complete, counts frozen |
| hit_count_o | output | CNT_W | Samples found below the reference |
| ref_count_o | output | CNT_W | Samples taken |

## Verification
The bench sweeps several comparator patterns on a 6-bit build: all zeros, all ones, periodic, and a burst at the window edge. Each expected hit count comes from summing the pattern over the two-cycle-delayed window. A synchronizer of the wrong depth, or a window off by one, shifts that sum or the done edge. Start pulses are injected mid-run and after completion, where a design that restarted would lose or reset its counts. Clear and start are raised together to catch a design that lets start win. A full-width 15-bit run confirms that the terminal value and the alternating-pattern count hold at the default size.

// File: rtl/rpc_pkg.sv
package rpc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } rpc_state_e;
endpackage

// File: rtl/rpc_sync.sv
module rpc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] pipe_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) pipe_q <= '0;
        else         pipe_q <= d_i;
    end else begin : g_many
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) pipe_q <= '0;
        else         pipe_q <= {pipe_q[STAGES-2:0], d_i};
    end
  endgenerate

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/rpc_counter.sv
module rpc_counter #(
  parameter int W = 15
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)    q_o <= '0;
    else if (clr_i) q_o <= '0;
    else if (inc_i) q_o <= q_o + W'(1);
endmodule

// File: rtl/rpc_ctrl.sv
module rpc_ctrl
  import rpc_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic start_i,
  input  logic last_i,
  output logic run_o,
  output logic done_o
);
  rpc_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (clear_i) state_d = ST_IDLE;  // clear beats start
    else begin
      unique case (state_q)
        ST_IDLE: if (start_i) state_d = ST_RUN;
        ST_RUN:  if (last_i)  state_d = ST_DONE;
        default: state_d = state_q;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;

  assign run_o  = (state_q == ST_RUN);
  assign done_o = (state_q == ST_DONE);
endmodule

// File: rtl/ripple_prob_counter.sv
module ripple_prob_counter #(
  parameter int CNT_W       = 15,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             start_i,
  input  logic             cmp_below_i,
  output logic             done_o,
  output logic [CNT_W-1:0] hit_count_o,
  output logic [CNT_W-1:0] ref_count_o
);
  localparam logic [CNT_W-1:0] LAST_REF = {{(CNT_W-1){1'b1}}, 1'b0};

  logic cmp_s, run, last;

  rpc_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(cmp_below_i), .q_o(cmp_s)
  );

  assign last = (ref_count_o == LAST_REF);

  rpc_ctrl u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .clear_i(clear_i), .start_i(start_i),
    .last_i(last), .run_o(run), .done_o(done_o)
  );

  rpc_counter #(.W(CNT_W)) u_ref_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clear_i), .inc_i(run),
    .q_o(ref_count_o)
  );

  rpc_counter #(.W(CNT_W)) u_hit_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clear_i), .inc_i(run & cmp_s),
    .q_o(hit_count_o)
  );
endmodule

// File: rtl/rpc_checker.sv
module rpc_checker #(
  parameter int CNT_W = 15
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             clear_i,
  input logic             done_o,
  input logic [CNT_W-1:0] hit_count_o,
  input logic [CNT_W-1:0] ref_count_o
);
  localparam logic [CNT_W-1:0] FULL = '1;

  // R2
  clear_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (ref_count_o == '0 && hit_count_o == '0 && !done_o));

  // R4
  ref_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ref_count_o != '0 && !done_o && !clear_i) |=>
      (ref_count_o == $past(ref_count_o) + CNT_W'(1)));

  // R5
  hit_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clear_i |=> (hit_count_o == $past(hit_count_o) ||
                  hit_count_o == $past(hit_count_o) + CNT_W'(1)));

  // R6
  done_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ref_count_o == FULL);

  // R7
  freeze_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !clear_i) |=> (done_o && $stable(hit_count_o) && $stable(ref_count_o)));

  // R10
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_count_o <= ref_count_o);
endmodule

bind ripple_prob_counter rpc_checker #(.CNT_W(CNT_W)) u_rpc_checker (
  .clk_i(clk_i), .rst_ni(rst_ni), .clear_i(clear_i), .done_o(done_o),
  .hit_count_o(hit_count_o), .ref_count_o(ref_count_o)
);

// File: tb/ripple_prob_counter_bench.sv
`timescale 1ns/1ps
module ripple_prob_counter_bench;
  localparam int SW = 6;
  localparam int SMAX = (1 << SW) - 1;
  localparam int BW = 15;
  localparam int BMAX = (1 << BW) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic s_clear = 0, s_start = 0, s_cmp = 0, s_done;
  logic [SW-1:0] s_hit, s_ref;
  logic b_clear = 0, b_start = 0, b_cmp = 0, b_done;
  logic [BW-1:0] b_hit, b_ref;

  int checks = 0;
  int failures = 0;
  int cyc = 0;

  ripple_prob_counter #(.CNT_W(SW)) u_ripple_prob_counter (
    .clk_i(clk), .rst_ni(rst_n), .clear_i(s_clear), .start_i(s_start),
    .cmp_below_i(s_cmp), .done_o(s_done), .hit_count_o(s_hit), .ref_count_o(s_ref)
  );

  ripple_prob_counter #(.CNT_W(BW)) u_big (
    .clk_i(clk), .rst_ni(rst_n), .clear_i(b_clear), .start_i(b_start),
    .cmp_below_i(b_cmp), .done_o(b_done), .hit_count_o(b_hit), .ref_count_o(b_ref)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 200000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected<=200000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  function automatic logic pat(input int mode, input int j);
    int k = j + 60;
    case (mode)
      0: return 1'b0;
      1: return 1'b1;
      2: return (k % 3) == 0;
      3: return (k % 2) == 1;
      default: return (j >= SMAX - 5);
    endcase
  endfunction

  // Runs one measurement on the small instance; cmp value for edge s+j is pat(j)
  task automatic run_small(input int mode, input bit poke_start);
    int exp_hit = 0;
    for (int j = -1; j <= SMAX - 2; j++) exp_hit += pat(mode, j);
    @(negedge clk); s_cmp = pat(mode, -1);
    @(negedge clk); s_start = 1; s_cmp = pat(mode, 0);
    for (int j = 1; j <= SMAX + 4; j++) begin
      @(negedge clk);
      s_start = (poke_start && j == 20);
      s_cmp = pat(mode, j);
      if (j - 1 == SMAX - 1) chk("R6 done early", s_done, 0);
      if (j - 1 == SMAX) chk("R6 done at full", s_done, 1);
      if (j == 10) chk("R4 ref mid-run", s_ref, 9);
    end
    chk("R4 ref final", s_ref, SMAX);
    chk(poke_start ? "R8 R5 hit with start mid-run" : "R5 hit count", s_hit, exp_hit);
    // R7/R8: start after done, toggling comparator
    s_start = 1; s_cmp = 1;
    @(negedge clk); s_start = 0; s_cmp = 0;
    repeat (4) @(negedge clk);
    chk("R7 R8 done held", s_done, 1);
    chk("R7 hit frozen", s_hit, exp_hit);
    chk("R7 ref frozen", s_ref, SMAX);
    s_clear = 1;
    @(negedge clk); s_clear = 0;
    chk("R2 clear ref", s_ref, 0);
    chk("R2 clear hit", s_hit, 0);
    chk("R2 clear done", s_done, 0);
  endtask

  initial begin
    #1;
    chk("R1 reset done", s_done, 0);
    chk("R1 reset hit", s_hit, 0);
    chk("R1 reset ref", s_ref, 0);
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R3: idle does not count
    s_cmp = 1;
    repeat (5) @(negedge clk);
    chk("R3 idle ref", s_ref, 0);
    chk("R3 idle hit", s_hit, 0);
    // R3: first counted sample at edge after start
    s_start = 1;
    @(negedge clk); s_start = 0;
    chk("R3 start edge no count", s_ref, 0);
    @(negedge clk);
    chk("R3 first sample", s_ref, 1);
    @(negedge clk);
    // R2: clear mid-run, then stays idle
    s_clear = 1;
    @(negedge clk); s_clear = 0;
    repeat (3) @(negedge clk);
    chk("R2 clear mid-run ref", s_ref, 0);
    chk("R2 clear mid-run hit", s_hit, 0);
    // R9: clear and start together
    s_clear = 1; s_start = 1;
    @(negedge clk); s_clear = 0; s_start = 0;
    repeat (3) @(negedge clk);
    chk("R9 clear wins ref", s_ref, 0);
    s_cmp = 0;

    for (int m = 0; m < 5; m++) run_small(m, 1'b0);
    run_small(2, 1'b1);
    run_small(4, 1'b1);

    // Full-width run, alternating comparator
    begin
      int exp_b = 0;
      for (int j = -1; j <= BMAX - 2; j++) exp_b += pat(3, j);
      @(negedge clk); b_cmp = pat(3, -1);
      @(negedge clk); b_start = 1; b_cmp = pat(3, 0);
      for (int j = 1; j <= BMAX + 2; j++) begin
        @(negedge clk);
        b_start = 0;
        b_cmp = pat(3, j);
        if (j - 1 == BMAX - 1) chk("R6 wide done early", b_done, 0);
      end
      chk("R6 wide done", b_done, 1);
      chk("R4 wide ref", b_ref, BMAX);
      chk("R5 wide hit", b_hit, exp_b);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule